// File: doc/BRIEF.md
# Unique Identifier Read Sequencer

This block hands software a 32-byte per-device identifier held in a protected non-volatile area. It hands it out one 4-byte word at a time. Software programs a start and an end address, sets an area-enable bit and writes a command byte. The sequencer fetches the word at its internal address after a fixed latency. It splits the word across two 16-bit read buffers and raises a data-ready flag. Each word is then released through a handshake on the command register. A write with the completion bit set closes the current read. A write of the same command with that bit clear moves on to the next word.

When the word at the end address has been consumed, the next advance raises a sequencer-ready flag instead of fetching. A command write whose low nibble is zero, called the end command, closes the sequence. The command codes for program, blank check and block erase are decoded and reported as finished at once. Any other nonzero code is illegal. An illegal code latches an error flag that only the end command clears. The identifier storage is a fixed table built at elaboration.

States: IDLE (waiting for a command), FETCH (latency count running), HOLD (buffers valid, data-ready high), PAUSE (read closed, waiting to advance), DONE (sequencer-ready high), ERR (error flag high). Transitions:
- IDLE→FETCH on a unique read with the completion bit clear and the area enabled.
- IDLE→DONE on program, blank check or erase.
- IDLE→ERR on an illegal code, on a unique read with the area disabled, or on a unique read with the completion bit set.
- FETCH→HOLD when the latency expires.
- HOLD→PAUSE on a unique read with the completion bit set.
- PAUSE→FETCH on a unique read with the completion bit clear while words remain.
- PAUSE→DONE on the same write once the end address has been passed.
- PAUSE→ERR on that write with the area disabled.
- HOLD→ERR and PAUSE→ERR on an illegal code.
- DONE→IDLE and ERR→IDLE on the end command.

Top module: `uid_read_seq`

## Requirements
- R1: After reset, data_ready, seq_ready and cmd_error are 0, and every register at bus offsets 0 to 6 reads 0.
- R2: The bus offsets are: 0 command byte, 1 start address, 2 end address, 3 high buffer, 4 low buffer, 5 area enable (bit 0), 6 status. The status word holds data-ready in bit 0, sequencer-ready in bit 1 and error in bit 2. The start and end address registers read back the value written.
- R3: The command byte carries the command code in bits 3:0 and the completion bit in bit 4; 0x85 is a unique read with completion clear and 0x95 the same with completion set. From IDLE with area enable 1, 0x85 sets data_ready exactly 3 clock edges after the edge that takes the write. At that point the buffers hold the word at the start address. Identifier byte k (k = 0..31, stored at address 0x0850+k) equals (37*k + 90) mod 256. The high buffer holds {byte at a+3, byte at a+2} and the low buffer holds {byte at a+1, byte at a}.
- R4: While data_ready is 1, a 0x95 write clears data_ready on the next edge and leaves both buffers unchanged.
- R5: After a 0x95 write, a 0x85 write adds 4 to the internal address and delivers the following word with the same 3-edge latency.
- R6: When the internal address plus 4 exceeds the end address, a 0x85 write from the wait state sets seq_ready and leaves data_ready at 0.
- R7: An end command (low nibble 0) while seq_ready is 1 clears seq_ready. A later 0x85 restarts at the start address.
- R8: A command with low nibble 2 or 6 to 15 sets cmd_error when written in IDLE, HOLD or PAUSE. An end command in IDLE does not set it.
- R9: While cmd_error is 1, every command other than the end command is ignored and all flags hold. The end command clears cmd_error.
- R10: A unique read issued with area enable 0 sets cmd_error.
- R11: Codes 1 (program), 3 (blank check) and 4 (erase) written in IDLE set seq_ready and leave data_ready at 0.
- R12: 0x95 written in IDLE sets cmd_error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| data_ready | output | 1 | Read buffers hold a fresh word |
| seq_ready | output | 1 | Command finished, waiting for end command |
| cmd_error | output | 1 | Illegal command latched |

## Verification
The bench aims at the exact latency edge: a sequencer that signals one cycle early or late misses the zero-then-one pattern sampled on each cycle. It walks random aligned sub-ranges so that the end-address comparison is tested at many boundaries. An off-by-one comparison there would fetch a word past the end or stop one word short. It injects illegal codes in every state that can accept them and then tries further commands. A design with a non-sticky error flag, or one that obeys commands while in error, shows changed flags. It also restarts after an end command, which a design that keeps the stale internal address would answer with the wrong first word.

// File: rtl/uid_pkg.sv
package uid_pkg;

    localparam int BUS_W  = 16;
    localparam int WORD_W = 32;

    localparam logic [3:0] CODE_END   = 4'h0;
    localparam logic [3:0] CODE_PROG  = 4'h1;
    localparam logic [3:0] CODE_BLANK = 4'h3;
    localparam logic [3:0] CODE_ERASE = 4'h4;
    localparam logic [3:0] CODE_UID   = 4'h5;

    localparam logic [2:0] OFF_CMD    = 3'd0;
    localparam logic [2:0] OFF_START  = 3'd1;
    localparam logic [2:0] OFF_END    = 3'd2;
    localparam logic [2:0] OFF_BUF_HI = 3'd3;
    localparam logic [2:0] OFF_BUF_LO = 3'd4;
    localparam logic [2:0] OFF_ENABLE = 3'd5;
    localparam logic [2:0] OFF_STATUS = 3'd6;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_FETCH = 3'd1,
        S_HOLD  = 3'd2,
        S_PAUSE = 3'd3,
        S_DONE  = 3'd4,
        S_ERR   = 3'd5
    } seq_state_t;

    function automatic logic [7:0] uid_byte(input int k);
        int v;
        v = (k * 37 + 90) & 255;
        return v[7:0];
    endfunction

endpackage

// File: rtl/uid_rom.sv
module uid_rom #(
    parameter int AW     = 16,
    parameter int BASE   = 16'h0850,
    parameter int NBYTES = 32
) (
    input  logic [AW-1:0] addr,
    output logic [31:0]   word
);
    localparam int IW = (NBYTES > 1) ? $clog2(NBYTES) : 1;

    logic [7:0] tbl [NBYTES];

    for (genvar g = 0; g < NBYTES; g++) begin : g_tbl
        assign tbl[g] = uid_pkg::uid_byte(g);
    end

    for (genvar j = 0; j < 4; j++) begin : g_lane
        int off;
        always_comb begin
            off = int'({1'b0, addr}) + j - BASE;
            if (off >= 0 && off < NBYTES) begin
                word[8*j +: 8] = tbl[off[IW-1:0]];
            end else begin
                word[8*j +: 8] = 8'h00;
            end
        end
    end

endmodule

// File: rtl/uid_lat_timer.sv
module uid_lat_timer #(
    parameter int LAT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);
    localparam int CW = (LAT > 1) ? $clog2(LAT) : 1;
    localparam logic [CW-1:0] LOAD = CW'(LAT - 1);

    logic [CW-1:0] cnt;
    logic          busy;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            busy <= 1'b0;
        end else if (start) begin
            cnt  <= LOAD;
            busy <= 1'b1;
        end else if (busy) begin
            if (cnt == '0) begin
                busy <= 1'b0;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    assign done = busy && (cnt == '0);

endmodule

// File: rtl/uid_seq_fsm.sv
module uid_seq_fsm
    import uid_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_wr,
    input  logic [7:0]    cmd_byte,
    input  logic          area_en,
    input  logic [AW-1:0] start_addr,
    input  logic [AW-1:0] end_addr,
    input  logic          tmr_done,
    output logic          tmr_start,
    output logic          load_buf,
    output logic [AW-1:0] cur_addr,
    output logic          data_ready,
    output logic          seq_ready,
    output logic          cmd_error
);
    seq_state_t    st, st_nx;
    logic [AW-1:0] addr_q, addr_nx;
    logic [3:0]    code;
    logic          drc;
    logic          is_end, is_uid, is_other, is_bad;
    logic [AW:0]   step_addr;
    logic          past_end;

    assign code = cmd_byte[3:0];
    assign drc  = cmd_byte[4];

    always_comb begin
        is_end   = (code == CODE_END);
        is_uid   = (code == CODE_UID);
        is_other = (code == CODE_PROG) || (code == CODE_BLANK) || (code == CODE_ERASE);
        is_bad   = !(is_end || is_uid || is_other);
    end

    assign step_addr = {1'b0, addr_q} + (AW+1)'(4);
    assign past_end  = step_addr > {1'b0, end_addr};

    always_comb begin
        st_nx     = st;
        addr_nx   = addr_q;
        tmr_start = 1'b0;
        if (cmd_wr) begin
            unique case (st)
                S_IDLE: begin
                    if (is_bad) begin
                        st_nx = S_ERR;
                    end else if (is_other) begin
                        st_nx = S_DONE;
                    end else if (is_uid) begin
                        if (!area_en || drc) begin
                            st_nx = S_ERR;
                        end else begin
                            addr_nx   = start_addr;
                            st_nx     = S_FETCH;
                            tmr_start = 1'b1;
                        end
                    end
                end
                S_FETCH: begin
                    st_nx = S_FETCH;
                end
                S_HOLD: begin
                    if (is_bad) begin
                        st_nx = S_ERR;
                    end else if (is_uid && drc) begin
                        st_nx = S_PAUSE;
                    end
                end
                S_PAUSE: begin
                    if (is_bad) begin
                        st_nx = S_ERR;
                    end else if (is_uid && !drc) begin
                        if (!area_en) begin
                            st_nx = S_ERR;
                        end else if (past_end) begin
                            st_nx = S_DONE;
                        end else begin
                            addr_nx   = step_addr[AW-1:0];
                            st_nx     = S_FETCH;
                            tmr_start = 1'b1;
                        end
                    end
                end
                S_DONE, S_ERR: begin
                    if (is_end) begin
                        addr_nx = start_addr;
                        st_nx   = S_IDLE;
                    end
                end
            endcase
        end
        if (st == S_FETCH && tmr_done) begin
            st_nx = S_HOLD;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= S_IDLE;
            addr_q <= '0;
        end else begin
            st     <= st_nx;
            addr_q <= addr_nx;
        end
    end

    always_comb begin
        load_buf   = (st == S_FETCH) && tmr_done;
        data_ready = (st == S_HOLD);
        seq_ready  = (st == S_DONE);
        cmd_error  = (st == S_ERR);
        cur_addr   = addr_q;
    end

    // R3
    rise_after_timer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_ready) |-> $past(tmr_done));

    // R4
    ready_drop_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(data_ready) |-> $past(cmd_wr));

    // R6
    seq_rise_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_ready) |-> $past(cmd_wr));

    // R9
    error_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_error && !(cmd_wr && cmd_byte[3:0] == CODE_END)) |=> cmd_error);

endmodule

// File: rtl/uid_read_seq.sv
module uid_read_seq
    import uid_pkg::*;
#(
    parameter int AW        = 16,
    parameter int UID_BASE  = 16'h0850,
    parameter int UID_BYTES = 32,
    parameter int LAT       = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic [2:0]  bus_addr,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    output logic        data_ready,
    output logic        seq_ready,
    output logic        cmd_error
);
    logic [7:0]    cmd_q;
    logic [AW-1:0] start_q, end_q;
    logic          en_q;
    logic [15:0]   buf_hi, buf_lo;
    logic          cmd_wr;
    logic          tmr_start, tmr_done, load_buf;
    logic [AW-1:0] cur_addr;
    logic [31:0]   rom_word;

    assign cmd_wr = bus_wr && (bus_addr == OFF_CMD);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q   <= '0;
            start_q <= '0;
            end_q   <= '0;
            en_q    <= 1'b0;
        end else if (bus_wr) begin
            case (bus_addr)
                OFF_CMD:    cmd_q   <= bus_wdata[7:0];
                OFF_START:  start_q <= bus_wdata[AW-1:0];
                OFF_END:    end_q   <= bus_wdata[AW-1:0];
                OFF_ENABLE: en_q    <= bus_wdata[0];
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_hi <= '0;
            buf_lo <= '0;
        end else if (load_buf) begin
            buf_hi <= rom_word[31:16];
            buf_lo <= rom_word[15:0];
        end
    end

    always_comb begin
        case (bus_addr)
            OFF_CMD:    bus_rdata = {8'h00, cmd_q};
            OFF_START:  bus_rdata = 16'(start_q);
            OFF_END:    bus_rdata = 16'(end_q);
            OFF_BUF_HI: bus_rdata = buf_hi;
            OFF_BUF_LO: bus_rdata = buf_lo;
            OFF_ENABLE: bus_rdata = {15'h0000, en_q};
            OFF_STATUS: bus_rdata = {13'h0000, cmd_error, seq_ready, data_ready};
            default:    bus_rdata = 16'h0000;
        endcase
    end

    uid_rom #(
        .AW(AW), .BASE(UID_BASE), .NBYTES(UID_BYTES)
    ) u_rom (
        .addr (cur_addr),
        .word (rom_word)
    );

    uid_lat_timer #(
        .LAT(LAT)
    ) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tmr_start),
        .done  (tmr_done)
    );

    uid_seq_fsm #(
        .AW(AW)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_wr     (cmd_wr),
        .cmd_byte   (bus_wdata[7:0]),
        .area_en    (en_q),
        .start_addr (start_q),
        .end_addr   (end_q),
        .tmr_done   (tmr_done),
        .tmr_start  (tmr_start),
        .load_buf   (load_buf),
        .cur_addr   (cur_addr),
        .data_ready (data_ready),
        .seq_ready  (seq_ready),
        .cmd_error  (cmd_error)
    );

    // R4
    buf_stable_while_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_ready && $past(data_ready)) |-> ($stable(buf_hi) && $stable(buf_lo)));

endmodule

// File: tb/sim_uid_read_seq.sv
module sim_uid_read_seq;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        data_ready, seq_ready, cmd_error;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uid_read_seq u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .data_ready(data_ready), .seq_ready(seq_ready), .cmd_error(cmd_error)
    );

    function automatic logic [7:0] id_b(input int a);
        int k = a - 16'h0850;
        int v = (37 * k + 90) % 256;
        return v[7:0];
    endfunction

    function automatic logic [15:0] exp_hi(input int a);
        return {id_b(a + 3), id_b(a + 2)};
    endfunction

    function automatic logic [15:0] exp_lo(input int a);
        return {id_b(a + 1), id_b(a)};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] off, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = off; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] off, output logic [15:0] d);
        bus_addr = off;
        #1;
        d = bus_rdata;
    endtask

    task automatic flags(input string req, input logic dr, input logic sr, input logic er);
        chk(req, {data_ready, seq_ready, cmd_error}, {dr, sr, er});
    endtask

    // issue 0x85 and check the R3/R5 three-edge latency, then the word
    task automatic fetch(input string req, input int a);
        logic [15:0] v;
        wr(3'd0, 16'h0085);
        chk(req, data_ready, 1'b0);
        @(negedge clk); chk(req, data_ready, 1'b0);
        @(negedge clk); chk(req, data_ready, 1'b0);
        @(negedge clk); chk(req, data_ready, 1'b1);
        rd(3'd3, v); chk(req, v, exp_hi(a));
        rd(3'd4, v); chk(req, v, exp_lo(a));
    endtask

    task automatic release_word(input int a);
        logic [15:0] v;
        wr(3'd0, 16'h0095);
        chk("R4", data_ready, 1'b0);
        rd(3'd3, v); chk("R4", v, exp_hi(a));
        rd(3'd4, v); chk("R4", v, exp_lo(a));
    endtask

    task automatic read_range(input int s, input int e);
        int a = s;
        wr(3'd1, 16'(s));
        wr(3'd2, 16'(e));
        fetch("R3", a);
        while (1) begin
            release_word(a);
            if (a + 4 > e) break;
            a += 4;
            fetch("R5", a);
        end
        wr(3'd0, 16'h0085);
        flags("R6", 1'b0, 1'b1, 1'b0);
        wr(3'd0, 16'h0000);
        flags("R7", 1'b0, 1'b0, 1'b0);
    endtask

    function automatic logic [7:0] bad_code();
        int r = $urandom_range(0, 10);
        return (r == 0) ? 8'h82 : 8'(8'h86 + r - 1);
    endfunction

    task automatic clear_err();
        wr(3'd0, 16'h0000);
        flags("R9", 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        flags("R1", 1'b0, 1'b0, 1'b0);
        for (int o = 0; o < 7; o++) begin
            rd(3'(o), v); chk("R1", v, 16'h0000);
        end

        // R2 register map readback
        wr(3'd1, 16'h0850);
        wr(3'd2, 16'h086F);
        rd(3'd1, v); chk("R2", v, 16'h0850);
        rd(3'd2, v); chk("R2", v, 16'h086F);

        // R10 area disabled
        wr(3'd0, 16'h0085);
        flags("R10", 1'b0, 1'b0, 1'b1);
        rd(3'd6, v); chk("R2", v, 16'h0004);
        // R9 ignored while in error
        wr(3'd5, 16'h0001);
        wr(3'd0, 16'h0085);
        repeat (4) @(negedge clk);
        flags("R9", 1'b0, 1'b0, 1'b1);
        wr(3'd0, 16'h0001);
        flags("R9", 1'b0, 1'b0, 1'b1);
        clear_err();

        // full identifier walk
        read_range(16'h0850, 16'h086F);

        // R7 restart at start address after end command
        fetch("R7", 16'h0850);
        release_word(16'h0850);

        // R8 bad code in wait state
        wr(3'd0, {8'h00, bad_code()});
        flags("R8", 1'b0, 1'b0, 1'b1);
        clear_err();
        // R8 bad code while holding
        fetch("R7", 16'h0850);
        wr(3'd0, {8'h00, bad_code()});
        flags("R8", 1'b0, 1'b0, 1'b1);
        clear_err();
        // R8 end command in idle is legal
        wr(3'd0, 16'h0000);
        flags("R8", 1'b0, 1'b0, 1'b0);
        // R8 bad codes in idle
        for (int i = 0; i < 6; i++) begin
            wr(3'd0, {8'h00, bad_code()});
            flags("R8", 1'b0, 1'b0, 1'b1);
            clear_err();
        end

        // R11 program, blank check, erase reported as done
        wr(3'd0, 16'h0081); flags("R11", 1'b0, 1'b1, 1'b0); wr(3'd0, 16'h0000);
        wr(3'd0, 16'h0083); flags("R11", 1'b0, 1'b1, 1'b0); wr(3'd0, 16'h0000);
        wr(3'd0, 16'h0084); flags("R11", 1'b0, 1'b1, 1'b0); wr(3'd0, 16'h0000);
        flags("R11", 1'b0, 1'b0, 1'b0);

        // R12 completion bit set from idle
        wr(3'd0, 16'h0095);
        flags("R12", 1'b0, 1'b0, 1'b1);
        clear_err();

        // random aligned sub-ranges
        for (int i = 0; i < 20; i++) begin
            int s = 16'h0850 + 4 * $urandom_range(0, 7);
            int e = s + 4 * $urandom_range(0, (16'h086C - s) / 4) + 3;
            read_range(s, e);
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule